// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer word fetcher and a display pipeline. It takes 32-bit words from a valid/ready stream and hands out one pixel per output transfer. A 3-bit format code, sampled together with each word, sets the bits per pixel, how many pixels the word yields and how each pixel's fields are read.

The four low-depth formats (1, 2, 4 and 8 bits) produce a palette index. Three 16-bit packings and one 24-bit packing produce a direct colour. Each channel is widened to 8 bits by copying its top bits into the freed low bits, and red and blue can be swapped. A byte-order control reverses the four bytes of a word before the pixels are read. A monochrome control is carried with each pixel as a flag. The palette lookup, memory fetching and panel timing are done by other blocks.

Top module: `pxu_unpacker`

## Requirements
- R1: While reset is held and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Format codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel and yield 32, 16, 8 and 4 pixels per word. The first pixel is taken from the least significant bits. Each pixel appears on `out_index` zero-extended to 8 bits, with `out_indexed` = 1 and `out_rgb` = 0.
- R3: Code 4 yields 2 pixels per word, the low halfword first. Red is bits 4:0, green bits 9:5, blue bits 14:10, and bit 15 is ignored. A 5-bit channel c becomes {c, c[4:2]}.
- R4: Code 6 yields 2 pixels per word. Red is bits 4:0, green bits 10:5 and blue bits 15:11. A 6-bit channel c becomes {c, c[5:4]}.
- R5: Code 7 yields 2 pixels per word. Red is bits 3:0, green bits 7:4, blue bits 11:8, and bits 15:12 are ignored. A 4-bit channel c becomes {c, c}.
- R6: Code 5 yields 1 pixel per word. Red is bits 7:0, green bits 15:8, blue bits 23:16, and bits 31:24 are ignored.
- R7: For direct formats, every pixel has `out_rgb` = {red, green, blue} with red in bits 23:16. `out_index` is 0. When `cfg_swap_rb` was 1 at word acceptance, red and blue exchange places. The swap has no effect on indexed formats.
- R8: When `cfg_byte_rev` was 1 at word acceptance, the word's bytes are reversed (byte 3 becomes byte 0) before pixels are read.
- R9: `in_ready` is 1 only when nothing is held, or when the pixel now being transferred is the last of the held word. A new word follows the last pixel with no idle cycle.
- R10: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows `out_valid` = 1 with unchanged `out_rgb`, `out_index` and `out_indexed`.
- R11: The format, swap, byte-order and monochrome controls are sampled only when a word is accepted. Changing them while a word is being unpacked does not affect its pixels.
- R12: `out_mono` equals the `cfg_mono` value that was sampled with the pixel's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Framebuffer word offered |
| in_ready | output | 1 | Word will be taken at this edge |
| in_word | input | 32 | Framebuffer word |
| cfg_mode | input | 3 | Format code (sampled with word) |
| cfg_swap_rb | input | 1 | Exchange red and blue for direct formats |
| cfg_mono | input | 1 | Monochrome marker carried to output |
| cfg_byte_rev | input | 1 | Reverse byte order of the word |
| out_valid | output | 1 | Pixel present |
| out_ready | input | 1 | Consumer takes pixel at this edge |
| out_index | output | 8 | Palette index, indexed formats |
| out_rgb | output | 24 | Expanded colour {R,G,B}, direct formats |
| out_indexed | output | 1 | Pixel is a palette index |
| out_mono | output | 1 | Sampled monochrome marker |

## Verification
The bench builds the block with its default 32-bit word, so the pixel counter runs through its full range. It wraps at 31 in the 1-bit format, and the 24-bit format yields single-pixel words. Both ends of the count are therefore covered, including back-to-back words where the last pixel and the next acceptance fall in the same cycle. Random back-pressure and control changes on every cycle exercise stalled outputs and the sampling of controls only at acceptance.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [2:0] {
        FMT_IDX1    = 3'd0,
        FMT_IDX2    = 3'd1,
        FMT_IDX4    = 3'd2,
        FMT_IDX8    = 3'd3,
        FMT_RGB5551 = 3'd4,
        FMT_RGB888  = 3'd5,
        FMT_RGB565  = 3'd6,
        FMT_RGB444  = 3'd7
    } fmt_e;

    localparam int CH_W  = 8;
    localparam int IDX_W = 8;
    localparam int RGB_W = 3 * CH_W;

    // log2 of the bits per pixel for each format
    function automatic logic [2:0] fmt_lg_bpp(fmt_e f);
        case (f)
            FMT_IDX1:    return 3'd0;
            FMT_IDX2:    return 3'd1;
            FMT_IDX4:    return 3'd2;
            FMT_IDX8:    return 3'd3;
            FMT_RGB888:  return 3'd5;
            default:     return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pxu_byte_order.sv
module pxu_byte_order #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              reverse,
    output logic [WORD_W-1:0] word_out
);
    localparam int NBYTES = WORD_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign word_out[b*8 +: 8] = reverse ? word_in[(NBYTES-1-b)*8 +: 8]
                                            : word_in[b*8 +: 8];
    end
endmodule

// File: rtl/pxu_field_pick.sv
module pxu_field_pick #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = $clog2(WORD_W),
    parameter int OUT_W  = 24
) (
    input  logic [WORD_W-1:0] word,
    input  logic [2:0]        lg_bpp,
    input  logic [CNT_W-1:0]  slot,
    output logic [OUT_W-1:0]  field
);
    localparam int SH_W = CNT_W + 6;

    logic [SH_W-1:0]   shamt;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        shamt   = SH_W'(slot) << lg_bpp;
        shifted = word >> shamt;
    end

    assign field = shifted[OUT_W-1:0];
    logic unused_high;
    assign unused_high = ^shifted[WORD_W-1:OUT_W];
endmodule

// File: rtl/pxu_color_expand.sv
module pxu_color_expand
    import pxu_pkg::*;
(
    input  fmt_e              fmt,
    input  logic [23:0]       field,
    input  logic              swap_rb,
    output logic [IDX_W-1:0]  index,
    output logic [RGB_W-1:0]  rgb,
    output logic              indexed
);
    logic [CH_W-1:0] red_c, grn_c, blu_c;
    logic [IDX_W-1:0] idx_c;

    always_comb begin
        red_c = '0;
        grn_c = '0;
        blu_c = '0;
        idx_c = '0;
        indexed = 1'b0;
        case (fmt)
            FMT_IDX1: begin idx_c = IDX_W'(field[0]);   indexed = 1'b1; end
            FMT_IDX2: begin idx_c = IDX_W'(field[1:0]); indexed = 1'b1; end
            FMT_IDX4: begin idx_c = IDX_W'(field[3:0]); indexed = 1'b1; end
            FMT_IDX8: begin idx_c = field[7:0];         indexed = 1'b1; end
            FMT_RGB5551: begin
                red_c = {field[4:0],   field[4:2]};
                grn_c = {field[9:5],   field[9:7]};
                blu_c = {field[14:10], field[14:12]};
            end
            FMT_RGB565: begin
                red_c = {field[4:0],   field[4:2]};
                grn_c = {field[10:5],  field[10:9]};
                blu_c = {field[15:11], field[15:13]};
            end
            FMT_RGB444: begin
                red_c = {field[3:0],  field[3:0]};
                grn_c = {field[7:4],  field[7:4]};
                blu_c = {field[11:8], field[11:8]};
            end
            default: begin
                red_c = field[7:0];
                grn_c = field[15:8];
                blu_c = field[23:16];
            end
        endcase
        index = idx_c;
        rgb   = swap_rb ? {blu_c, grn_c, red_c} : {red_c, grn_c, blu_c};
    end
endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
    import pxu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_swap_rb,
    input  logic              cfg_mono,
    input  logic              cfg_byte_rev,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [IDX_W-1:0]  out_index,
    output logic [RGB_W-1:0]  out_rgb,
    output logic              out_indexed,
    output logic              out_mono
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] word;
        fmt_e              fmt;
        logic              swap;
        logic              mono;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] ordered_word;
    logic [2:0]        lg_bpp;
    logic [CNT_W-1:0]  last_cnt;
    logic              is_last;
    logic              take_in;
    logic              take_out;
    logic [23:0]       field;

    pxu_byte_order #(.WORD_W(WORD_W)) u_order (
        .word_in  (in_word),
        .reverse  (cfg_byte_rev),
        .word_out (ordered_word)
    );

    pxu_field_pick #(.WORD_W(WORD_W), .CNT_W(CNT_W), .OUT_W(24)) u_pick (
        .word   (st_q.word),
        .lg_bpp (lg_bpp),
        .slot   (st_q.cnt),
        .field  (field)
    );

    pxu_color_expand u_expand (
        .fmt     (st_q.fmt),
        .field   (field),
        .swap_rb (st_q.swap),
        .index   (out_index),
        .rgb     (out_rgb),
        .indexed (out_indexed)
    );

    always_comb begin
        lg_bpp   = fmt_lg_bpp(st_q.fmt);
        last_cnt = CNT_W'((WORD_W >> lg_bpp) - 1);
        is_last  = (st_q.cnt == last_cnt);
        take_out = st_q.full && out_ready;
        in_ready = !st_q.full || (out_ready && is_last);
        take_in  = in_valid && in_ready;

        st_d = st_q;
        if (take_out) begin
            if (is_last) begin
                st_d.full = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (take_in) begin
            st_d.full = 1'b1;
            st_d.word = ordered_word;
            st_d.fmt  = fmt_e'(cfg_mode);
            st_d.swap = cfg_swap_rb;
            st_d.mono = cfg_mono;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{full: 1'b0, word: '0, fmt: FMT_IDX1, swap: 1'b0,
                      mono: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.full;
    assign out_mono  = st_q.mono;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rgb)
            && $stable(out_index) && $stable(out_indexed)); // R10
    AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !is_last |-> !in_ready); // R9
    AST_ACCEPT_STARTS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && st_q.cnt == '0); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.full |-> st_q.cnt <= last_cnt); // R9
    AST_IDX_RGB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_indexed |-> out_rgb == '0); // R2
    AST_DIRECT_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_indexed |-> out_index == '0); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(in_valid && in_ready) |=> $stable(st_q.fmt)
            && $stable(st_q.swap) && $stable(out_mono)); // R11
endmodule

// File: tb/pxu_unpacker_bench.sv
module pxu_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready;
    logic [31:0] in_word;
    logic [2:0]  cfg_mode;
    logic        cfg_swap_rb, cfg_mono, cfg_byte_rev;
    logic        out_valid, out_ready;
    logic [7:0]  out_index;
    logic [23:0] out_rgb;
    logic        out_indexed, out_mono;

    always #5 clk = ~clk;

    pxu_unpacker u_pxu_unpacker (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .cfg_mode(cfg_mode), .cfg_swap_rb(cfg_swap_rb), .cfg_mono(cfg_mono),
        .cfg_byte_rev(cfg_byte_rev),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_index(out_index), .out_rgb(out_rgb),
        .out_indexed(out_indexed), .out_mono(out_mono)
    );

    typedef struct packed {
        logic        last;
        logic        indexed;
        logic        mono;
        logic [7:0]  idx;
        logic [23:0] rgb;
    } pix_t;

    int total = 0;
    int bad   = 0;
    pix_t  exp_q[$];
    string tag_q[$];

    localparam int NDIR   = 9;
    localparam int NRAND  = 300;
    localparam int LIMIT  = 150000;

    function automatic logic [7:0] ex5(int x); return 8'((x << 3) | (x >> 2)); endfunction
    function automatic logic [7:0] ex6(int x); return 8'((x << 2) | (x >> 4)); endfunction
    function automatic logic [7:0] ex4(int x); return 8'((x << 4) | x);        endfunction

    function automatic int bpp_of(int m);
        case (m)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            5: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic pix_t model(logic [31:0] w, int m, bit swp, bit brev, bit mono, int k);
        pix_t p;
        logic [31:0] ww;
        longint f;
        int bpp;
        logic [7:0] r, g, b;
        ww  = brev ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        bpp = bpp_of(m);
        f   = (longint'(ww) >> (k * bpp)) & ((64'd1 << bpp) - 1);
        p.last = (k == 32 / bpp - 1);
        p.mono = mono;
        r = 0; g = 0; b = 0;
        if (m < 4) begin
            p.indexed = 1'b1;
            p.idx     = 8'(f);
            p.rgb     = '0;
        end else begin
            p.indexed = 1'b0;
            p.idx     = '0;
            case (m)
                4: begin r = ex5(int'(f & 31)); g = ex5(int'((f >> 5) & 31)); b = ex5(int'((f >> 10) & 31)); end
                6: begin r = ex5(int'(f & 31)); g = ex6(int'((f >> 5) & 63)); b = ex5(int'((f >> 11) & 31)); end
                7: begin r = ex4(int'(f & 15)); g = ex4(int'((f >> 4) & 15)); b = ex4(int'((f >> 8) & 15)); end
                default: begin r = 8'(f); g = 8'(f >> 8); b = 8'(f >> 16); end
            endcase
            p.rgb = swp ? {b, g, r} : {r, g, b};
        end
        return p;
    endfunction

    function automatic string tag_of(int m, bit swp, bit brev);
        if (brev) return "R8";
        if (swp && m >= 4) return "R7";
        case (m)
            0, 1, 2, 3: return "R2";
            4: return "R3";
            6: return "R4";
            7: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // directed corner words: word, mode, swap, byte reverse, mono
    logic [31:0] d_word [NDIR] = '{32'h8000_0001, 32'h1122_3344, 32'h801F_001F,
                                   32'h801F_001F, 32'h07E0_F800, 32'hF123_0A5C,
                                   32'hAB12_3456, 32'hAB12_3456, 32'h9C3E_5A71};
    int          d_mode [NDIR] = '{0, 3, 4, 4, 6, 7, 5, 5, 1};
    bit          d_swap [NDIR] = '{1, 0, 0, 1, 0, 0, 0, 1, 0};
    bit          d_brev [NDIR] = '{0, 1, 0, 0, 0, 0, 0, 0, 0};
    bit          d_mono [NDIR] = '{0, 0, 0, 0, 1, 0, 0, 0, 1};

    initial begin
        int   wi, cyc;
        bit   have, stall_prev, directed;
        logic [31:0] cur_word;
        logic [2:0]  acc_mode;
        logic [23:0] prev_rgb;
        logic [7:0]  prev_idx;
        logic        prev_ixd;
        pix_t e;
        string t;

        void'($urandom(32'd4242));
        rst_n = 1'b0;
        in_valid = 0; in_word = 0; cfg_mode = 0; cfg_swap_rb = 0;
        cfg_mono = 0; cfg_byte_rev = 0; out_ready = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready in reset", 64'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "idle after reset",
              64'({out_valid, in_ready}), 64'b01);

        wi = 0; cyc = 0; have = 0; stall_prev = 0; cur_word = 0; acc_mode = 0;
        prev_rgb = 0; prev_idx = 0; prev_ixd = 0;
        while ((wi < NDIR + NRAND || have || exp_q.size() != 0) && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
            if (stall_prev) begin
                check(out_valid && out_rgb == prev_rgb && out_index == prev_idx
                      && out_indexed == prev_ixd, "R10", "stalled pixel changed",
                      64'({out_valid, out_indexed, out_index, out_rgb}),
                      64'({1'b1, prev_ixd, prev_idx, prev_rgb}));
            end
            directed = (wi < NDIR);
            if (!have && wi < NDIR + NRAND) begin
                have = 1;
                cur_word = directed ? d_word[wi] : $urandom;
            end
            in_valid = have && (directed || ($urandom % 3 != 0));
            in_word  = cur_word;
            if (directed) begin
                cfg_mode     = 3'(d_mode[wi]);
                cfg_swap_rb  = d_swap[wi];
                cfg_byte_rev = d_brev[wi];
                cfg_mono     = d_mono[wi];
            end else begin
                // R11: controls move every cycle; only the accepted values count
                cfg_mode     = 3'($urandom % 8);
                cfg_swap_rb  = 1'($urandom % 2);
                cfg_byte_rev = 1'($urandom % 4 == 0);
                cfg_mono     = 1'($urandom % 2);
            end
            out_ready = ($urandom % 4 != 0);
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected pixel", 64'(out_rgb), 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (t != "R8" && in_valid && cfg_mode != acc_mode) t = "R11";
                    check(out_indexed == e.indexed && out_index == e.idx && out_rgb == e.rgb,
                          t, "pixel value",
                          64'({out_indexed, out_index, out_rgb}),
                          64'({e.indexed, e.idx, e.rgb}));
                    check(out_mono == e.mono, "R12", "mono flag", 64'(out_mono), 64'(e.mono));
                    check(in_ready == e.last, "R9", "in_ready vs last pixel",
                          64'(in_ready), 64'(e.last));
                end
            end else if (out_valid) begin
                check(in_ready == 1'b0, "R9", "in_ready while stalled", 64'(in_ready), 0);
            end
            stall_prev = out_valid && !out_ready;
            prev_rgb = out_rgb; prev_idx = out_index; prev_ixd = out_indexed;
            if (in_valid && in_ready) begin
                acc_mode = cfg_mode;
                for (int k = 0; k < 32 / bpp_of(int'(cfg_mode)); k++) begin
                    exp_q.push_back(model(cur_word, int'(cfg_mode), cfg_swap_rb,
                                          cfg_byte_rev, cfg_mono, k));
                    tag_q.push_back(tag_of(int'(cfg_mode), cfg_swap_rb, cfg_byte_rev));
                end
                have = 0;
                wi++;
            end
        end
        if (cyc >= LIMIT) check(0, "R9", "watchdog expired", 64'(cyc), LIMIT);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule